// File: doc/BRIEF.md
# Address-Encoded Cartridge Bank Mapper

This block sits on a 13-bit cartridge address bus and decides which memory answers each access. The upper half of the address space, from $1000 to $1FFF, is cartridge space. A selected 4K ROM bank always covers $1200-$1FFF. When RAM is switched on, the lowest 512 bytes of cartridge space go to a 256-byte RAM page instead. The first 256 bytes of that range read the page, and the next 256 bytes write it.

The control registers are set by the address of a write alone. A write to the lower half ($0000-$0FFF) whose low address byte equals the variant's tag is decoded as a register write. Address bits 11:8 then carry the command. The data bus plays no part.

The `VARIANT` parameter selects one of three layouts:
- Variant 0 (tag $3D): an independent 3-bit ROM bank and a 2-bit RAM page.
- Variant 1 (tag $3C): a 2-bit ROM bank and a 3-bit RAM page.
- Variant 2 (tag $3B): a 3-bit bank that selects both the ROM bank and a group of four RAM pages, with a 2-bit page within that group.

The block drives:
- the physical ROM and RAM addresses,
- the two chip selects,
- the RAM write strobe.

Top module: `addr_bank_mapper`

## Requirements
- R1: After reset, RAM is disabled and both the ROM bank and the RAM page are 0. A read of $1010 then selects ROM at ROM address $0010.
- R2: Any access in $1200-$1FFF asserts `rom_cs` only. `rom_addr` is bank*4096 plus address bits 11:0.
- R3: With RAM enabled, an access in $1000-$10FF asserts `ram_cs` without a strobe. A write in $1100-$11FF asserts `ram_cs` and `ram_we`. In both cases `ram_addr` is page*256 plus address bits 7:0.
- R4: With RAM disabled, $1000-$11FF is served by ROM (`rom_cs`=1, `ram_cs`=0), and a write there never asserts `ram_we`.
- R5: A register write whose address bits 11:8 are 4'b0010 enables RAM. A register write whose bits 11:8 are 4'b0011 disables it. The change takes effect from the next clock cycle.
- R6: A register write needs `bus_wr`=1, A12=0 and address bits 7:0 equal to the tag. Reads, other low bytes, and command codes 4'b0000 and 4'b0001 leave all state unchanged.
- R7: Variant 0, tag $3D. Bits 11:10=01 load the RAM page from bits 9:8. Bit 11=1 loads the ROM bank from bits 10:8.
- R8: Variant 1, tag $3C. Bits 11:10=01 load a 2-bit ROM bank from bits 9:8. Bit 11=1 loads a 3-bit RAM page from bits 10:8.
- R9: Variant 2, tag $3B. Bit 11=1 loads the bank from bits 10:8, and this bank selects the ROM bank. Bits 11:10=01 load a 2-bit sub-page. The RAM page is bank*4 plus the sub-page.
- R10: `rom_cs` and `ram_cs` are never both high. `ram_we` is high only together with `ram_cs` and `bus_wr`. Addresses below $1000 assert neither chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Address of the current bus cycle |
| bus_wr | input | 1 | High for a write cycle, one clock per access |
| rom_addr | output | 15 | ROM address: 3-bit bank above 12 offset bits |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 13 | RAM address: 5-bit page above 8 offset bits |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |

## Verification
The bench targets the boundary between the RAM read half and the RAM write half at $1100. It also targets the boundary between the RAM window and permanent ROM at $1200, and the behaviour of both when RAM is switched off. A design that misplaced either boundary would corrupt RAM on reads, or hide ROM code behind RAM.

The bench also tries near-miss register writes:
- a read of a register address,
- a wrong low byte,
- the unused command codes.

A sloppy decoder would take any of these as a bank switch, and the next ROM address would show it.

For variants 1 and 2, the bench checks the swapped field roles and the combined bank-plus-page RAM address. A mapper that reused one variant's wiring for another would point at the wrong page.

// File: rtl/addr_bank_mapper.sv
module addr_bank_mapper #(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 3,
  parameter int PAGE_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  output logic [BANK_W+11:0]       rom_addr,
  output logic                     rom_cs,
  output logic [PAGE_W+7:0]        ram_addr,
  output logic                     ram_cs,
  output logic                     ram_we
);

  localparam logic [7:0] TAG = (VARIANT == 0) ? 8'h3D :
                               (VARIANT == 1) ? 8'h3C : 8'h3B;

  logic [2:0] hi_q;
  logic [1:0] lo_q;
  logic       ram_en_q;
  logic       reg_hit;
  logic [3:0] cmd;
  logic [BANK_W-1:0] bank;
  logic [PAGE_W-1:0] page;
  logic       cart;
  logic       low_win;

  assign cmd     = bus_addr[11:8];
  assign reg_hit = bus_wr && !bus_addr[12] && (bus_addr[7:0] == TAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      ram_en_q <= 1'b0;
    end else if (reg_hit) begin
      if (cmd[3])
        hi_q <= cmd[2:0];
      else if (cmd[2])
        lo_q <= cmd[1:0];
      else if (cmd[1])
        ram_en_q <= ~cmd[0];
    end
  end

  generate
    if (VARIANT == 1) begin : g_swap
      assign bank = BANK_W'({1'b0, lo_q});
      assign page = PAGE_W'(hi_q);
    end else if (VARIANT == 2) begin : g_tied
      assign bank = BANK_W'(hi_q);
      assign page = PAGE_W'({hi_q, lo_q});
    end else begin : g_indep
      assign bank = BANK_W'(hi_q);
      assign page = PAGE_W'(lo_q);
    end
  endgenerate

  assign cart    = bus_addr[12];
  assign low_win = cart && (bus_addr[11:9] == 3'b000) && ram_en_q;

  assign rom_cs   = cart && !low_win;
  assign ram_cs   = low_win;
  assign ram_we   = low_win && bus_addr[8] && bus_wr;
  assign rom_addr = {bank, bus_addr[11:0]};
  assign ram_addr = {page, bus_addr[7:0]};

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs)); // R10
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && bus_wr)); // R10
  AST_HIGH_IS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[12] && bus_addr[11:9] != 3'b000) |-> (rom_cs && !ram_cs)); // R2
  AST_LOW_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[12] |-> (!rom_cs && !ram_cs && !ram_we)); // R10
  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |=> ($stable(hi_q) && $stable(lo_q) && $stable(ram_en_q))); // R6
  AST_RAM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && cmd == 4'h2) |=> ram_en_q); // R5
  AST_RAM_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && cmd == 4'h3) |=> !ram_en_q); // R5

endmodule

// File: tb/tb_addr_bank_mapper.sv
module tb_addr_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [14:0] rom_addr, rom_addr1, rom_addr2;
  logic [12:0] ram_addr, ram_addr1, ram_addr2;
  logic        rom_cs, ram_cs, ram_we;
  logic        rom_cs1, ram_cs1, ram_we1;
  logic        rom_cs2, ram_cs2, ram_we2;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_bank_mapper #(.VARIANT(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .ram_addr(ram_addr),
    .ram_cs(ram_cs), .ram_we(ram_we));
  addr_bank_mapper #(.VARIANT(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .rom_addr(rom_addr1), .rom_cs(rom_cs1), .ram_addr(ram_addr1),
    .ram_cs(ram_cs1), .ram_we(ram_we1));
  addr_bank_mapper #(.VARIANT(2)) dut_v2 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .rom_addr(rom_addr2), .rom_cs(rom_cs2), .ram_addr(ram_addr2),
    .ram_cs(ram_cs2), .ram_we(ram_we2));

  // {wr, addr[12:0], rom_cs, ram_cs, ram_we, rom_addr[14:0], ram_addr[12:0], req[3:0]}
  localparam int NV = 19;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 13'h1000, 3'b100, 15'h0000, 13'h0000, 4'd1},  // R1 reset state
    {1'b1, 13'h0B3D, 3'b000, 15'h0B3D, 13'h003D, 4'd7},  // R7 bank 3
    {1'b0, 13'h1234, 3'b100, 15'h3234, 13'h0034, 4'd2},  // R2
    {1'b1, 13'h023D, 3'b000, 15'h323D, 13'h003D, 4'd5},  // R5 enable
    {1'b0, 13'h1010, 3'b010, 15'h3010, 13'h0010, 4'd3},  // R3 read half
    {1'b1, 13'h063D, 3'b000, 15'h363D, 13'h003D, 4'd7},  // R7 page 2
    {1'b1, 13'h1155, 3'b011, 15'h3155, 13'h0255, 4'd3},  // R3 write half
    {1'b0, 13'h1100, 3'b010, 15'h3100, 13'h0200, 4'd3},  // R3
    {1'b1, 13'h1055, 3'b010, 15'h3055, 13'h0255, 4'd3},  // R3 no strobe on read half
    {1'b1, 13'h0F7D, 3'b000, 15'h3F7D, 13'h027D, 4'd6},  // R6 wrong tag
    {1'b0, 13'h0F3D, 3'b000, 15'h3F3D, 13'h023D, 4'd6},  // R6 read of register
    {1'b0, 13'h1FFF, 3'b100, 15'h3FFF, 13'h02FF, 4'd6},  // R6 bank still 3
    {1'b1, 13'h033D, 3'b000, 15'h333D, 13'h023D, 4'd5},  // R5 disable
    {1'b0, 13'h1010, 3'b100, 15'h3010, 13'h0210, 4'd4},  // R4
    {1'b1, 13'h1155, 3'b100, 15'h3155, 13'h0255, 4'd4},  // R4 no strobe
    {1'b1, 13'h0F3D, 3'b000, 15'h3F3D, 13'h023D, 4'd7},  // R7 bank 7
    {1'b0, 13'h1200, 3'b100, 15'h7200, 13'h0200, 4'd2},  // R2 boundary
    {1'b1, 13'h013D, 3'b000, 15'h713D, 13'h023D, 4'd6},  // R6 code 0001
    {1'b0, 13'h1FFC, 3'b100, 15'h7FFC, 13'h02FC, 4'd6}   // R6 unchanged
  };

  task automatic cmp(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [12:0] a);
    @(negedge clk);
    bus_wr = wr;
    bus_addr = a;
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][48], VEC[i][47:35]);
      cmp($sformatf("R%0d row %0d", VEC[i][3:0], i),
          {rom_cs, ram_cs, ram_we, rom_addr, ram_addr}, VEC[i][34:4]);
    end
    // R1: reset clears enable, bank and page
    cyc(1'b1, 13'h023D);
    cyc(1'b0, 13'h1010);
    cmp("R5 re-enable", {rom_cs, ram_cs, ram_we, rom_addr, ram_addr}, {3'b010, 15'h7010, 13'h0210});
    rst_n = 1'b0;
    cyc(1'b0, 13'h1010);
    rst_n = 1'b1;
    cyc(1'b0, 13'h1010);
    cmp("R1 after reset", {rom_cs, ram_cs, ram_we, rom_addr, ram_addr}, {3'b100, 15'h0010, 13'h0010});
    // R10: low space selects nothing
    cyc(1'b1, 13'h0F3D);
    cmp("R10 low space", {rom_cs, ram_cs, ram_we}, 31'(3'b000));
    // R8: variant 1, tag 3C
    cyc(1'b1, 13'h053C);
    cyc(1'b1, 13'h0E3C);
    cyc(1'b1, 13'h023C);
    cyc(1'b0, 13'h1800);
    cmp("R8 rom bank", {rom_cs1, ram_cs1, ram_we1, rom_addr1}, {16'h0, 3'b100, 15'h1800});
    cyc(1'b1, 13'h11A0);
    cmp("R8 ram page", {rom_cs1, ram_cs1, ram_we1, ram_addr1}, {15'h0, 3'b011, 13'h06A0});
    // R9: variant 2, tag 3B
    cyc(1'b1, 13'h0D3B);
    cyc(1'b1, 13'h073B);
    cyc(1'b1, 13'h023B);
    cyc(1'b0, 13'h1044);
    cmp("R9 tied page", {rom_cs2, ram_cs2, ram_we2, ram_addr2}, {15'h0, 3'b010, 13'h1744});
    cyc(1'b0, 13'h1200);
    cmp("R9 rom bank", {rom_cs2, ram_cs2, ram_we2, rom_addr2}, {13'h0, 3'b100, 15'h5200});
    // R6: other tags left variant 2 bank alone; variant 0 untouched by 3C/3B writes
    cmp("R6 cross tag", {rom_cs, rom_addr}, {15'h0, 1'b1, 15'h7200});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule